// File: doc/BRIEF.md
# Opcode-Bit Arithmetic/Logic Unit

This unit computes one result from two operands. The operation is not chosen by an enumerated code. It comes from a small opcode whose bits each carry a separate meaning: unit mode, carry chaining, end-around carry, flag capture, operand inversion and carry-in.

In arithmetic mode a single ripple full-adder chain forms A + B' + c. Here B' is B or its bitwise inverse, and c is chosen from the opcode carry-in, the saved carry or zero. The following operations all come from this one chain:

- increment
- two's-complement subtraction
- register copy
- the literals 0 and 1
- multi-word addition
- ones'-complement sums

In logic mode the carry-in and invert bits stop acting on the adder. Together they select a bitwise gate instead.

The result output is purely combinational. The status flags (carry, zero, negative) are held in a three-bit register. That register is written on a clock edge only when the save bit of the opcode is set. Each operand can be replaced by a hardwired zero source, so no extra datapath is needed for constants or moves. The block has no data stream of its own and therefore no valid/ready handshake: it is meant to sit inside a datapath that presents operands and an opcode every cycle and consumes the result in the same cycle.

Top module: `opbit_alu`

## Requirements
- R1: Opcode bit 5 (the most significant) selects the unit. A value of 0 gives the adder result and 1 gives the bitwise gate result. In logic mode, opcode bits 4 and 3 have no effect on the result.
- R2: In logic mode the pair {opcode[1], opcode[0]} selects the gate as follows: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 (reserved) also gives A XOR B.
- R3: In arithmetic mode, with opcode bits 4 and 3 clear, result = A + B + opcode[0] modulo 2^W. Opcode bit 0 set therefore increments.
- R4: When a_zero or b_zero is high, the corresponding operand reads as 0 in both modes. ZERO+ZERO gives 0, ZERO+ZERO with carry-in gives 1, and A+ZERO copies A.
- R5: In arithmetic mode, opcode bit 1 inverts B. With bits 1 and 0 both set, the result is A - B in two's complement, and the carry flag records 1 when A >= B (no borrow).
- R6: When opcode bit 2 is set, the next clock edge loads flags[0] = carry, flags[1] = (result == 0) and flags[2] = result MSB. In arithmetic mode the carry is the adder carry-out; in logic mode it is 0.
- R7: When opcode bit 2 is clear, the flags register keeps its value across the clock edge.
- R8: When opcode bit 4 is set in arithmetic mode, the stored flags[0] replaces opcode bit 0 as the adder carry-in, so words can be chained into wider sums.
- R9: When opcode bit 3 is set and bit 4 is clear in arithmetic mode, the adder runs with carry-in 0 and opcode bit 0 is ignored. Its carry-out is then added back into the least significant bit, which gives a ones'-complement sum, and the saved carry is that first carry-out. Chaining (bit 4) takes precedence over end-around carry.
- R10: A synchronous active-high rst clears the flags register to 0. This has priority over a save.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| opcode | input | 6 | Bit 5 mode, bit 4 chain, bit 3 end-around, bit 2 save, bit 1 invert-B, bit 0 carry-in |
| a_zero | input | 1 | Replace operand A with the zero source |
| b_zero | input | 1 | Replace operand B with the zero source |
| a_data | input | W (8) | Operand A |
| b_data | input | W (8) | Operand B |
| result | output | W (8) | Combinational result |
| flags | output | 3 | Registered {negative, zero, carry} |

## Verification
The hardest cases to reach from the ports depend on the flags register's history, not on the present inputs. These are chained carry, the precedence of chaining over end-around carry, and the carry being cleared by a saving logic operation. The vector table is therefore walked strictly in order, and each such vector is placed right after one that leaves a known carry in the flags. For example, the chain-plus-wrap vector follows an addition that overflows, so that the two possible precedences produce different results. The no-write case is reached by first loading the flags with a distinctive pattern and then issuing an operation without the save bit whose flags would differ.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
  localparam int OPW      = 6;
  localparam int OP_CIN   = 0;
  localparam int OP_INVB  = 1;
  localparam int OP_SAVE  = 2;
  localparam int OP_WRAP  = 3;
  localparam int OP_CHAIN = 4;
  localparam int OP_MODE  = 5;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
  } alu_flags_t;

  typedef enum logic [1:0] {
    GATE_AND     = 2'b00,
    GATE_OR      = 2'b01,
    GATE_XOR     = 2'b10,
    GATE_XOR_RSV = 2'b11
  } gate_sel_e;
endpackage

// File: rtl/opalu_ripple_adder.sv
module opalu_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign cout = carry[W];
endmodule

// File: rtl/opalu_gate_unit.sv
module opalu_gate_unit
  import opalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  gate_sel_e    sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      GATE_AND: y = a & b;
      GATE_OR:  y = a | b;
      default:  y = a ^ b;   // XOR and the reserved code
    endcase
  end
endmodule

// File: rtl/opalu_flag_reg.sv
module opalu_flag_reg
  import opalu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       save,
  input  alu_flags_t next_f,
  output alu_flags_t flags_q
);
  always_ff @(posedge clk) begin
    if (rst)       flags_q <= '0;
    else if (save) flags_q <= next_f;
  end

  assert_hold_when_unsaved_R7: assert property (@(posedge clk) disable iff (rst)
    !save |=> $stable(flags_q));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (flags_q == '0));
endmodule

// File: rtl/opbit_alu.sv
module opbit_alu
  import opalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           a_zero,
  input  logic           b_zero,
  input  logic [W-1:0]   a_data,
  input  logic [W-1:0]   b_data,
  output logic [W-1:0]   result,
  output logic [2:0]     flags
);
  logic is_logic, do_chain, do_wrap, do_save, do_invb, op_cin;
  assign is_logic = opcode[OP_MODE];
  assign do_chain = opcode[OP_CHAIN];
  assign do_wrap  = opcode[OP_WRAP];
  assign do_save  = opcode[OP_SAVE];
  assign do_invb  = opcode[OP_INVB];
  assign op_cin   = opcode[OP_CIN];

  // Operand sources: hardwired zero or the data input (R4)
  logic [W-1:0] opa, opb_raw, opb_add;
  assign opa     = a_zero ? '0 : a_data;
  assign opb_raw = b_zero ? '0 : b_data;
  assign opb_add = do_invb ? ~opb_raw : opb_raw;

  alu_flags_t flags_q, flags_d;

  // Carry-in priority: saved carry, then end-around (first pass uses 0), then opcode bit
  logic cin_sel, wrap_active;
  assign wrap_active = do_wrap & ~do_chain;
  always_comb begin
    if (do_chain)     cin_sel = flags_q.carry;
    else if (do_wrap) cin_sel = 1'b0;
    else              cin_sel = op_cin;
  end

  logic [W-1:0] sum1, sum2;
  logic         cout1, cout2;

  opalu_ripple_adder #(.W(W)) u_add_main (
    .a(opa), .b(opb_add), .cin(cin_sel), .sum(sum1), .cout(cout1)
  );

  opalu_ripple_adder #(.W(W)) u_add_wrap (
    .a(sum1), .b('0), .cin(wrap_active & cout1), .sum(sum2), .cout(cout2)
  );

  logic [W-1:0] gate_y;
  opalu_gate_unit #(.W(W)) u_gates (
    .a(opa), .b(opb_raw), .sel(gate_sel_e'({do_invb, op_cin})), .y(gate_y)
  );

  assign result = is_logic ? gate_y : sum2;

  assign flags_d.carry = is_logic ? 1'b0 : cout1;
  assign flags_d.zero  = (result == '0);
  assign flags_d.neg   = result[W-1];

  opalu_flag_reg u_flags (
    .clk(clk), .rst(rst), .save(do_save), .next_f(flags_d), .flags_q(flags_q)
  );

  assign flags = flags_q;

  assert_logic_carry_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (is_logic && do_save) |=> !flags[0]);

  assert_zero_flag_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    do_save |=> (flags[1] == ($past(result) == '0)));

  assert_subtract_R5: assert property (@(posedge clk) disable iff (rst)
    (!is_logic && !do_chain && !do_wrap && do_invb && op_cin)
      |-> (result == W'(opa - opb_raw)));

  assert_zero_literal_R4: assert property (@(posedge clk) disable iff (rst)
    (!is_logic && !do_chain && !do_wrap && !do_invb && a_zero && b_zero)
      |-> (result == {{(W-1){1'b0}}, op_cin}));

  assert_wrap_no_spill_R9: assert property (@(posedge clk) disable iff (rst)
    !cout2);
endmodule

// File: tb/opbit_alu_test.sv
`timescale 1ns/1ps
module opbit_alu_test;
  localparam int W  = 8;
  localparam int NV = 26;

  logic         clk = 1'b0;
  logic         rst;
  logic [5:0]   opcode;
  logic         a_zero, b_zero;
  logic [W-1:0] a_data, b_data;
  logic [W-1:0] result;
  logic [2:0]   flags;

  always #4 clk = ~clk;   // 125 MHz

  opbit_alu #(.W(W)) uut (
    .clk(clk), .rst(rst), .opcode(opcode), .a_zero(a_zero), .b_zero(b_zero),
    .a_data(a_data), .b_data(b_data), .result(result), .flags(flags)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // {req, opcode, a_zero, b_zero, a, b, expected result, expected {neg,zero,carry}}
  // Opcode bits: 5 mode, 4 chain, 3 wrap, 2 save, 1 invert-B, 0 carry-in
  localparam logic [38:0] VEC [NV] = '{
    {4'd3, 6'h04, 1'b0, 1'b0, 8'h12, 8'h34, 8'h46, 3'b000}, // R3 add
    {4'd3, 6'h04, 1'b0, 1'b0, 8'h80, 8'h80, 8'h00, 3'b011}, // R3 overflow
    {4'd3, 6'h05, 1'b0, 1'b1, 8'h7F, 8'h55, 8'h80, 3'b100}, // R3 increment
    {4'd4, 6'h05, 1'b1, 1'b1, 8'h33, 8'h44, 8'h01, 3'b000}, // R4 literal 1
    {4'd4, 6'h04, 1'b1, 1'b1, 8'h33, 8'h44, 8'h00, 3'b010}, // R4 literal 0
    {4'd4, 6'h04, 1'b0, 1'b1, 8'h9C, 8'h11, 8'h9C, 3'b100}, // R4 move
    {4'd5, 6'h07, 1'b0, 1'b0, 8'h50, 8'h20, 8'h30, 3'b001}, // R5 sub no borrow
    {4'd5, 6'h07, 1'b0, 1'b0, 8'h20, 8'h50, 8'hD0, 3'b100}, // R5 sub borrow
    {4'd5, 6'h07, 1'b0, 1'b0, 8'h44, 8'h44, 8'h00, 3'b011}, // R5 sub equal
    {4'd2, 6'h24, 1'b0, 1'b0, 8'hF0, 8'h3C, 8'h30, 3'b000}, // R2 AND
    {4'd2, 6'h25, 1'b0, 1'b0, 8'hF0, 8'h0C, 8'hFC, 3'b100}, // R2 OR
    {4'd2, 6'h26, 1'b0, 1'b0, 8'hAA, 8'hAA, 8'h00, 3'b010}, // R2 XOR
    {4'd2, 6'h27, 1'b0, 1'b0, 8'h0F, 8'hF3, 8'hFC, 3'b100}, // R2 reserved -> XOR
    {4'd1, 6'h04, 1'b0, 1'b0, 8'h0F, 8'h01, 8'h10, 3'b000}, // R1 arithmetic
    {4'd1, 6'h26, 1'b0, 1'b0, 8'h0F, 8'h01, 8'h0E, 3'b000}, // R1 logic, same operands
    {4'd6, 6'h04, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 3'b011}, // R6 set carry
    {4'd6, 6'h24, 1'b0, 1'b0, 8'hFF, 8'h81, 8'h81, 3'b100}, // R6 logic clears carry
    {4'd9, 6'h0C, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h01, 3'b001}, // R9 end-around
    {4'd9, 6'h0D, 1'b0, 1'b0, 8'h10, 8'h20, 8'h30, 3'b000}, // R9 op carry-in ignored
    {4'd9, 6'h0C, 1'b0, 1'b0, 8'hFE, 8'hFE, 8'hFD, 3'b101}, // R9 ones' complement sum
    {4'd9, 6'h0E, 1'b0, 1'b0, 8'h05, 8'h03, 8'h02, 3'b001}, // R9 ones' complement diff
    {4'd8, 6'h14, 1'b0, 1'b0, 8'h10, 8'h20, 8'h31, 3'b000}, // R8 saved carry 1 used
    {4'd8, 6'h15, 1'b0, 1'b0, 8'h10, 8'h20, 8'h30, 3'b000}, // R8 saved 0 overrides op
    {4'd8, 6'h04, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 3'b011}, // R8 preload carry
    {4'd8, 6'h1C, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 3'b011}, // R8 chain beats wrap
    {4'd1, 6'h3D, 1'b0, 1'b0, 8'h0F, 8'h30, 8'h3F, 3'b000}  // R1 chain/wrap ignored
  };

  task automatic drive(input logic [5:0] op, input logic az, input logic bz,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    opcode = op; a_zero = az; b_zero = bz; a_data = a; b_data = b;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(6'h00, 1'b0, 1'b0, '0, '0);
    repeat (2) @(posedge clk);
    #1 chk("R10 flags after reset", {5'b0, flags}, 8'h00);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [3:0]   rq;
      logic [5:0]   op;
      logic         az, bz;
      logic [W-1:0] a, b, er;
      logic [2:0]   ef;
      {rq, op, az, bz, a, b, er, ef} = VEC[i];
      @(negedge clk);
      drive(op, az, bz, a, b);
      #1 chk($sformatf("R%0d vector %0d result", rq, i), result, er);
      @(posedge clk);
      #1 chk($sformatf("R%0d vector %0d flags", rq, i), {5'b0, flags}, {5'b0, ef});
    end

    // R7: flags held when the save bit is clear
    @(negedge clk);
    drive(6'h04, 1'b0, 1'b0, 8'h80, 8'h80);      // flags -> 011
    @(posedge clk);
    #1 chk("R7 preload flags", {5'b0, flags}, 8'h03);
    @(negedge clk);
    drive(6'h00, 1'b0, 1'b0, 8'h81, 8'h01);      // would give 100
    #1 chk("R7 unsaved add result", result, 8'h82);
    @(posedge clk);
    #1 chk("R7 flags kept after arithmetic", {5'b0, flags}, 8'h03);
    @(negedge clk);
    drive(6'h20, 1'b0, 1'b0, 8'hF0, 8'hFF);      // logic AND, no save
    #1 chk("R7 unsaved AND result", result, 8'hF0);
    @(posedge clk);
    #1 chk("R7 flags kept after logic", {5'b0, flags}, 8'h03);

    // R10: reset wins over a simultaneous save
    @(negedge clk);
    drive(6'h04, 1'b0, 1'b0, 8'hFF, 8'h81);
    rst = 1'b1;
    @(posedge clk);
    #1 chk("R10 reset over save", {5'b0, flags}, 8'h00);
    @(negedge clk) rst = 1'b0;
    drive(6'h00, 1'b0, 1'b0, '0, '0);
    @(posedge clk);
    #1 chk("R10 flags stay clear", {5'b0, flags}, 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule